// File: doc/BRIEF.md
# Flagged Dual-Word I/O Port

This block is one logical I/O port shared between a processor core and a peripheral device. The port holds two data words, a single status bit and a one-bit word pointer. The core reaches the port through a read strobe and a write strobe. Each strobe carries a 3-bit mode field with three independent flags:

- a test flag that makes the access conditional on the status bit;
- a status flag that updates the status after the access;
- an address flag that moves the pointer to the other word after the access.

The flags may be combined in any pattern. When an access is skipped, nothing in the port changes.

The device side sees both words and the status bit at all times. It can overwrite either word or the status bit directly, without the core's flag rules. A system instantiates many of these ports, for example a bank of 256 behind a lock arbiter. This block models one of them.

Top module: `fdwp_port`

## Requirements
- R1: On synchronous reset both words, the status bit and the word pointer are zero, and `core_rdata` and `core_done` are zero.
- R2: A core read that is performed returns the word selected by the pointer on `core_rdata`, with `core_done` high, in the cycle after the strobe.
- R3: A core write that is performed stores `core_wdata` into the word selected by the pointer. `core_done` is high and `core_rdata` is zero in the next cycle.
- R4: With mode bit 0 (test) set, a read is performed only when the status is 1, and a write only when the status is 0. A skipped access gives `core_done` low and `core_rdata` zero, and it changes no word, status or pointer.
- R5: With mode bit 1 (status) set, a performed read clears the status and a performed write sets it. With the bit clear, the status is unchanged.
- R6: With mode bit 2 (address) set, a performed access toggles the word pointer afterwards, so successive reads return word 0, word 1, word 0. With the bit clear, the pointer holds.
- R7: When both strobes are high in one cycle, only the write is considered and the read is ignored.
- R8: A device write of word 0 or word 1 (`dev_sel`), or of the status bit, is visible on `dev_words`/`dev_status` one cycle later. In the same cycle, a performed core write to the same word wins over the device write. A performed core access with the status flag wins over a device status write.
- R9: With neither strobe high, `core_done` and `core_rdata` are zero in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_rd | input | 1 | Core read strobe |
| core_wr | input | 1 | Core write strobe |
| core_mode | input | 3 | Flags: bit0 test, bit1 status, bit2 address |
| core_wdata | input | W | Core write data |
| core_rdata | output | W | Read data, one cycle after the strobe |
| core_done | output | 1 | Access performed, one cycle after the strobe |
| dev_wr | input | 1 | Device word write enable |
| dev_sel | input | 1 | Device word select |
| dev_wdata | input | W | Device write data |
| dev_status_wr | input | 1 | Device status write enable |
| dev_status_val | input | 1 | Device status value |
| dev_words | output | 2*W | Word 1 in the high half, word 0 in the low half |
| dev_status | output | 1 | Current status bit |

## Verification
Every result is registered once. `core_rdata`, `core_done`, `dev_words` and `dev_status` all reflect a strobe exactly one rising edge after it. The bench drives inputs on the falling edge and samples on the next falling edge, one full cycle later. Its model computes the expected outputs from its own state before that edge, then updates the state.

// File: rtl/fdwp_pkg.sv
package fdwp_pkg;

    localparam int NUM_WORDS = 2;

    typedef struct packed {
        logic addr;   // bit 2
        logic stat;   // bit 1
        logic test;   // bit 0
    } mode_t;

    typedef struct packed {
        logic perf;
        logic is_rd;
        logic is_wr;
        logic stat_upd;
        logic stat_val;
        logic ptr_flip;
    } action_t;

    function automatic action_t decide(logic rd, logic wr, mode_t m, logic status);
        action_t a;
        logic    want_wr;
        logic    want_rd;
        logic    gate_ok;
        want_wr    = wr;
        want_rd    = rd && !wr;
        gate_ok    = !m.test || (want_wr ? !status : status);
        a.perf     = (want_wr || want_rd) && gate_ok;
        a.is_wr    = want_wr && a.perf;
        a.is_rd    = want_rd && a.perf;
        a.stat_upd = a.perf && m.stat;
        a.stat_val = want_wr;
        a.ptr_flip = a.perf && m.addr;
        return a;
    endfunction

endpackage

// File: rtl/fdwp_gate.sv
module fdwp_gate
    import fdwp_pkg::*;
(
    input  logic    rd,
    input  logic    wr,
    input  mode_t   mode,
    input  logic    status,
    output action_t act
);
    always_comb act = decide(rd, wr, mode, status);
endmodule

// File: rtl/fdwp_word_bank.sv
module fdwp_word_bank
    import fdwp_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   core_we,
    input  logic                   core_sel,
    input  logic [W-1:0]           core_data,
    input  logic                   dev_we,
    input  logic                   dev_sel,
    input  logic [W-1:0]           dev_data,
    output logic [NUM_WORDS*W-1:0] words
);
    for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
        logic [W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= '0;
            else if (core_we && (core_sel == 1'(i)))
                q <= core_data;
            else if (dev_we && (dev_sel == 1'(i)))
                q <= dev_data;
        end
        assign words[i*W +: W] = q;
    end
endmodule

// File: rtl/fdwp_ctrl.sv
module fdwp_ctrl
    import fdwp_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  action_t act,
    input  logic    dev_status_wr,
    input  logic    dev_status_val,
    output logic    status,
    output logic    ptr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            status <= 1'b0;
            ptr    <= 1'b0;
        end else begin
            if (act.stat_upd)
                status <= act.stat_val;
            else if (dev_status_wr)
                status <= dev_status_val;
            if (act.ptr_flip)
                ptr <= ~ptr;
        end
    end
endmodule

// File: rtl/fdwp_port.sv
module fdwp_port
    import fdwp_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   core_rd,
    input  logic                   core_wr,
    input  logic [2:0]             core_mode,
    input  logic [W-1:0]           core_wdata,
    output logic [W-1:0]           core_rdata,
    output logic                   core_done,
    input  logic                   dev_wr,
    input  logic                   dev_sel,
    input  logic [W-1:0]           dev_wdata,
    input  logic                   dev_status_wr,
    input  logic                   dev_status_val,
    output logic [NUM_WORDS*W-1:0] dev_words,
    output logic                   dev_status
);
    action_t act;
    logic    status_q;
    logic    ptr_q;
    logic [W-1:0] sel_word;

    fdwp_gate u_gate (
        .rd     (core_rd),
        .wr     (core_wr),
        .mode   (mode_t'(core_mode)),
        .status (status_q),
        .act    (act)
    );

    fdwp_ctrl u_ctrl (
        .clk            (clk),
        .rst            (rst),
        .act            (act),
        .dev_status_wr  (dev_status_wr),
        .dev_status_val (dev_status_val),
        .status         (status_q),
        .ptr            (ptr_q)
    );

    fdwp_word_bank #(.W(W)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .core_we   (act.is_wr),
        .core_sel  (ptr_q),
        .core_data (core_wdata),
        .dev_we    (dev_wr),
        .dev_sel   (dev_sel),
        .dev_data  (dev_wdata),
        .words     (dev_words)
    );

    assign sel_word   = dev_words[ptr_q*W +: W];
    assign dev_status = status_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            core_rdata <= '0;
            core_done  <= 1'b0;
        end else begin
            core_rdata <= act.is_rd ? sel_word : '0;
            core_done  <= act.perf;
        end
    end
endmodule

// File: rtl/fdwp_port_chk.sv
module fdwp_port_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         core_rd,
    input logic         core_wr,
    input logic [2:0]   core_mode,
    input logic [W-1:0] core_rdata,
    input logic         core_done,
    input logic         dev_status
);
    // R4
    skip_rd_chk: assert property (@(posedge clk) disable iff (rst)
        (core_rd && !core_wr && core_mode[0] && !dev_status) |=> (!core_done && core_rdata == '0));

    // R4
    skip_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (core_wr && core_mode[0] && dev_status) |=> !core_done);

    // R5
    wr_sets_stat_chk: assert property (@(posedge clk) disable iff (rst)
        (core_wr && core_mode[1] && (!core_mode[0] || !dev_status)) |=> dev_status);

    // R5
    rd_clears_stat_chk: assert property (@(posedge clk) disable iff (rst)
        (core_rd && !core_wr && core_mode[1] && (!core_mode[0] || dev_status)) |=> !dev_status);

    // R7
    both_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (core_rd && core_wr && (!core_mode[0] || !dev_status)) |=> (core_done && core_rdata == '0));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!core_rd && !core_wr) |=> (!core_done && core_rdata == '0));
endmodule

bind fdwp_port fdwp_port_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .core_rd    (core_rd),
    .core_wr    (core_wr),
    .core_mode  (core_mode),
    .core_rdata (core_rdata),
    .core_done  (core_done),
    .dev_status (dev_status)
);

// File: tb/fdwp_port_test.sv
`timescale 1ns/1ps
module fdwp_port_test;
    localparam int W = 16;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           core_rd = 0, core_wr = 0;
    logic [2:0]     core_mode = 0;
    logic [W-1:0]   core_wdata = 0;
    logic [W-1:0]   core_rdata;
    logic           core_done;
    logic           dev_wr = 0, dev_sel = 0;
    logic [W-1:0]   dev_wdata = 0;
    logic           dev_status_wr = 0, dev_status_val = 0;
    logic [2*W-1:0] dev_words;
    logic           dev_status;

    int n_checks = 0;
    int n_fail   = 0;

    // model state
    logic [W-1:0] m_w0 = 0, m_w1 = 0;
    logic         m_st = 0, m_ptr = 0;

    always #2.5 clk = ~clk;

    fdwp_port #(.W(W)) uut (.*);

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic gate_ok(logic rd, logic wr, logic [2:0] md, logic st);
        if (!rd && !wr) return 1'b0;
        if (!md[0])     return 1'b1;
        return wr ? !st : st;
    endfunction

    // drive at negedge, check at next negedge
    task automatic step(input logic rd, input logic wr, input logic [2:0] md,
                        input logic [W-1:0] wd, input logic dw, input logic ds,
                        input logic [W-1:0] dd, input logic dsw, input logic dsv,
                        input string req);
        logic          perf;
        logic          is_rd;
        logic          is_wr;
        logic [W-1:0]  exp_rd;
        logic [W-1:0]  nw0, nw1;
        logic          nst, nptr;
        core_rd = rd; core_wr = wr; core_mode = md; core_wdata = wd;
        dev_wr = dw; dev_sel = ds; dev_wdata = dd;
        dev_status_wr = dsw; dev_status_val = dsv;
        perf  = gate_ok(rd, wr, md, m_st);
        is_wr = perf && wr;
        is_rd = perf && !wr;
        exp_rd = is_rd ? (m_ptr ? m_w1 : m_w0) : '0;
        nw0 = m_w0; nw1 = m_w1; nst = m_st; nptr = m_ptr;
        if (dw && !ds) nw0 = dd;
        if (dw &&  ds) nw1 = dd;
        if (is_wr && !m_ptr) nw0 = wd;
        if (is_wr &&  m_ptr) nw1 = wd;
        if (dsw) nst = dsv;
        if (perf && md[1]) nst = is_wr;
        if (perf && md[2]) nptr = ~m_ptr;
        m_w0 = nw0; m_w1 = nw1; m_st = nst; m_ptr = nptr;
        @(posedge clk);
        @(negedge clk);
        check({req, " done"},   64'(core_done),  64'(perf));
        check({req, " rdata"},  64'(core_rdata), 64'(exp_rd));
        check({req, " words"},  64'(dev_words),  64'({m_w1, m_w0}));
        check({req, " status"}, 64'(dev_status), 64'(m_st));
    endtask

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 done",   64'(core_done),  0);
        check("R1 rdata",  64'(core_rdata), 0);
        check("R1 words",  64'(dev_words),  0);
        check("R1 status", 64'(dev_status), 0);
        // R9 idle
        step(0,0,3'b000,16'hFFFF,0,0,0,0,0,"R9");
        // R3 plain write word0, R6 advance pointer
        step(0,1,3'b100,16'hA0A0,0,0,0,0,0,"R3 R6");
        step(0,1,3'b000,16'hB1B1,0,0,0,0,0,"R3");
        // R2/R6 alternating reads: word1, word0, word1
        step(1,0,3'b100,0,0,0,0,0,0,"R2 R6");
        step(1,0,3'b100,0,0,0,0,0,0,"R2 R6");
        step(1,0,3'b000,0,0,0,0,0,0,"R2");
        // R4 test read with status 0 skipped
        step(1,0,3'b111,0,0,0,0,0,0,"R4");
        // R5 test write with status 0 sets status
        step(0,1,3'b011,16'h1234,0,0,0,0,0,"R4 R5");
        // R4 test write skipped with status 1
        step(0,1,3'b101,16'hDEAD,0,0,0,0,0,"R4");
        // R5 test read clears status
        step(1,0,3'b111,0,0,0,0,0,0,"R5");
        // R7 both strobes
        step(1,1,3'b000,16'h7777,0,0,0,0,0,"R7");
        // R8 device writes and conflicts
        step(0,0,3'b000,0,1,1,16'hCAFE,1,1,"R8");
        step(0,1,3'b000,16'h5555,1,0,16'h9999,0,0,"R8 conflict");
        step(1,0,3'b010,0,0,0,0,1,1,"R8 status conflict");
        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[0] & r[1], r[2] & r[3], r[6:4], 16'($urandom),
                 r[7] & r[8], r[9], 16'($urandom), r[10] & r[11], r[12], "R2 R3 R4 R5 R6 R7 R8");
        end
        // R1 reset again
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        rst = 1'b0;
        m_w0 = 0; m_w1 = 0; m_st = 0; m_ptr = 0;
        check("R1 words",  64'(dev_words),  0);
        check("R1 status", 64'(dev_status), 0);
        step(1,0,3'b000,0,0,0,0,0,0,"R1 ptr");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule